// File: doc/BRIEF.md
# Stage-Count Parity Alarm for a Reversible Cascade

This block is a chain of reversible logic stages. Each stage carries one extra wire, the parity wire, beside its data lanes. The parity wire starts at 0 and every stage inverts it exactly once. At the end of the chain its value therefore gives the parity of the number of stages that actually ran. A checker at the end compares that value with an expected value and raises an alarm when they differ. If a stage drops out of the chain or runs twice, the count changes by one and the wire ends on the wrong value.

Stages at even positions are four-wire controlled-XOR gates: two control lanes, one target lane and the parity wire. Stages at odd positions are three-wire copy/invert gates: one source lane, one target lane and the parity wire. The checker receives two candidate expectations, one for an even count and one for an odd count. A select input chooses which one applies. A fault-injection port can remove any single stage or run it twice, so the alarm path can be exercised in use. The whole block is combinational.

Top module: `dl_stage_checker`

## Requirements
- R1: With no fault injected, the select input set to the parity of N_STAGES, exp_even_i=0 and exp_odd_i=1, alarm_o is 0 for every data input. The parity wire enters at 0 and each stage inverts it once.
- R2: The final parity-wire value differs between an even and an odd count of stages that ran. With one stage skipped or repeated, setting the select input to the other parity clears the alarm.
- R3: The stage at even index k maps lane (k+2)%DATA_W to itself XOR (lane k%DATA_W AND lane (k+1)%DATA_W). All other lanes pass through unchanged.
- R4: The stage at odd index k maps lane (k+1)%DATA_W to itself XOR lane k%DATA_W XOR INVERT (INVERT=0 by default). All other lanes pass through unchanged.
- R5: odd_sel_i=1 selects exp_odd_i and odd_sel_i=0 selects exp_even_i. alarm_o is 1 exactly when the final parity-wire value differs from the selected expectation.
- R6: With flt_kind_i=1 (skip) and flt_idx_i=k < N_STAGES, stage k is bypassed on both data and parity wire, and alarm_o rises under the R1 settings.
- R7: With flt_kind_i=2 (repeat) and flt_idx_i=k < N_STAGES, stage k is applied twice, and alarm_o rises under the R1 settings.
- R8: With flt_kind_i=0 (none) or 3 (reserved), or with flt_idx_i >= N_STAGES, no stage is altered: data_o and alarm_o equal the fault-free result.
- R9: data_o and alarm_o are combinational functions of the present inputs and hold no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | DATA_W | Data lanes entering the cascade |
| odd_sel_i | input | 1 | 1 selects the odd-count expectation, 0 the even-count one |
| exp_even_i | input | 1 | Expected final parity-wire value for an even stage count |
| exp_odd_i | input | 1 | Expected final parity-wire value for an odd stage count |
| flt_kind_i | input | 2 | Fault kind: 0 none, 1 skip, 2 repeat, 3 reserved (none) |
| flt_idx_i | input | IDX_W | Index of the stage the fault targets |
| data_o | output | DATA_W | Data lanes leaving the cascade |
| alarm_o | output | 1 | High when the stage count disagrees with the selected expectation |

## Verification
Immediate assertions check the following whenever the inputs are known:
- every stage applied once inverts the parity wire;
- a stage applied twice leaves its lanes and the parity wire where they started;
- a clean, correctly configured cascade keeps the alarm low;
- any in-range skip or repeat raises the alarm.

Only the bench scenarios can show that each stage's lane mapping is right for every data pattern. The same holds for whether the selected expectation is the right one and whether out-of-range indices and the reserved kind truly leave the output untouched. The bench computes the expected data for every stage index and both fault kinds from the lane rules above.

// File: rtl/dl_pkg.sv
package dl_pkg;

  // Fault kind carried on flt_kind_i
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_SKIP  = 2'd1,
    FLT_TWICE = 2'd2,
    FLT_RSVD  = 2'd3
  } fault_kind_e;

  // How one stage slot behaves in the current configuration
  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_ONCE  = 2'd1,
    MODE_TWICE = 2'd2
  } stage_mode_e;

  function automatic stage_mode_e slot_mode(input fault_kind_e kind, input logic hit);
    stage_mode_e m;
    m = MODE_ONCE;
    if (hit) begin
      case (kind)
        FLT_SKIP:  m = MODE_PASS;
        FLT_TWICE: m = MODE_TWICE;
        default:   m = MODE_ONCE;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/dl_logic_stage.sv
// Four-wire reversible stage: controlled-XOR on one data lane plus parity wire inversion.
module dl_logic_stage #(
  parameter int DATA_W = 4,
  parameter int LANE_A = 0,
  parameter int LANE_B = 1,
  parameter int LANE_T = 2
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              det_i,
  output logic [DATA_W-1:0] data_o,
  output logic              det_o
);

  always_comb begin
    data_o         = data_i;
    data_o[LANE_T] = data_i[LANE_T] ^ (data_i[LANE_A] & data_i[LANE_B]);
    det_o          = ~det_i;
  end

endmodule

// File: rtl/dl_fanout_stage.sv
// Three-wire reversible stage: copies (or inverts) a source lane into a target lane.
module dl_fanout_stage #(
  parameter int DATA_W = 4,
  parameter int LANE_S = 0,
  parameter int LANE_T = 1,
  parameter bit INVERT = 1'b0
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              det_i,
  output logic [DATA_W-1:0] data_o,
  output logic              det_o
);

  always_comb begin
    data_o         = data_i;
    data_o[LANE_T] = data_i[LANE_T] ^ data_i[LANE_S] ^ INVERT;
    det_o          = ~det_i;
  end

endmodule

// File: rtl/dl_stage_slot.sv
// One position in the cascade. The variant is picked by the stage index.
// Two passes of the stage are built so that a repeat fault can be modelled.
module dl_stage_slot
  import dl_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int IDX    = 0,
  parameter bit INVERT = 1'b0
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              det_i,
  input  stage_mode_e       mode_i,
  output logic [DATA_W-1:0] data_o,
  output logic              det_o
);

  localparam int L0 = IDX % DATA_W;
  localparam int L1 = (IDX + 1) % DATA_W;
  localparam int L2 = (IDX + 2) % DATA_W;

  logic [DATA_W-1:0] p1_data, p2_data;
  logic              p1_det,  p2_det;

  generate
    if (IDX % 2 == 0) begin : g_logic
      dl_logic_stage #(.DATA_W(DATA_W), .LANE_A(L0), .LANE_B(L1), .LANE_T(L2)) u_pass1 (
        .data_i(data_i),  .det_i(det_i),  .data_o(p1_data), .det_o(p1_det));
      dl_logic_stage #(.DATA_W(DATA_W), .LANE_A(L0), .LANE_B(L1), .LANE_T(L2)) u_pass2 (
        .data_i(p1_data), .det_i(p1_det), .data_o(p2_data), .det_o(p2_det));
    end else begin : g_fanout
      dl_fanout_stage #(.DATA_W(DATA_W), .LANE_S(L0), .LANE_T(L1), .INVERT(INVERT)) u_pass1 (
        .data_i(data_i),  .det_i(det_i),  .data_o(p1_data), .det_o(p1_det));
      dl_fanout_stage #(.DATA_W(DATA_W), .LANE_S(L0), .LANE_T(L1), .INVERT(INVERT)) u_pass2 (
        .data_i(p1_data), .det_i(p1_det), .data_o(p2_data), .det_o(p2_det));
    end
  endgenerate

  always_comb begin
    case (mode_i)
      MODE_PASS:  begin data_o = data_i;  det_o = det_i;  end
      MODE_TWICE: begin data_o = p2_data; det_o = p2_det; end
      default:    begin data_o = p1_data; det_o = p1_det; end
    endcase
  end

  // Each stage variant is self-inverse, and a single pass flips the parity wire.
  always_comb begin
    if (!$isunknown({data_i, det_i, mode_i})) begin
      a_r3_self_inverse: assert (p2_data == data_i && p2_det == det_i)
        else $error("R3/R4: stage %0d applied twice did not restore its inputs", IDX);
      if (mode_i == MODE_ONCE) begin
        a_r1_one_flip: assert (det_o != det_i)
          else $error("R1: stage %0d did not invert the parity wire", IDX);
      end
      if (mode_i == MODE_TWICE) begin
        a_r7_twice_keeps: assert (det_o == det_i)
          else $error("R7: repeated stage %0d changed the parity wire", IDX);
      end
    end
  end

endmodule

// File: rtl/dl_collector.sv
// End-of-chain comparator: chooses the expectation and flags a mismatch.
module dl_collector (
  input  logic det_i,
  input  logic odd_sel_i,
  input  logic exp_even_i,
  input  logic exp_odd_i,
  output logic alarm_o
);

  logic expected;

  always_comb begin
    expected = odd_sel_i ? exp_odd_i : exp_even_i;
    alarm_o  = det_i ^ expected;
  end

endmodule

// File: rtl/dl_stage_checker.sv
module dl_stage_checker
  import dl_pkg::*;
#(
  parameter int N_STAGES = 6,
  parameter int DATA_W   = 4,
  parameter bit INVERT   = 1'b0,
  parameter int IDX_W    = $clog2(N_STAGES) + 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              odd_sel_i,
  input  logic              exp_even_i,
  input  logic              exp_odd_i,
  input  logic [1:0]        flt_kind_i,
  input  logic [IDX_W-1:0]  flt_idx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              alarm_o
);

  // DATA_W must be at least 3 so that a logic stage has three distinct lanes.
  localparam logic N_ODD = logic'(N_STAGES % 2);

  logic [DATA_W-1:0] data_c [0:N_STAGES];
  logic              det_c  [0:N_STAGES];
  fault_kind_e       kind;

  assign kind      = fault_kind_e'(flt_kind_i);
  assign data_c[0] = data_i;
  assign det_c[0]  = 1'b0;

  generate
    for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
      stage_mode_e mode;
      assign mode = slot_mode(kind, flt_idx_i == IDX_W'(k));
      dl_stage_slot #(.DATA_W(DATA_W), .IDX(k), .INVERT(INVERT)) u_slot (
        .data_i(data_c[k]),
        .det_i (det_c[k]),
        .mode_i(mode),
        .data_o(data_c[k+1]),
        .det_o (det_c[k+1])
      );
    end
  endgenerate

  dl_collector u_collector (
    .det_i     (det_c[N_STAGES]),
    .odd_sel_i (odd_sel_i),
    .exp_even_i(exp_even_i),
    .exp_odd_i (exp_odd_i),
    .alarm_o   (alarm_o)
  );

  assign data_o = data_c[N_STAGES];

  // Port-level relation between fault configuration and alarm.
  logic fault_live, well_set;
  always_comb begin
    fault_live = (flt_kind_i == 2'd1 || flt_kind_i == 2'd2) && (int'(flt_idx_i) < N_STAGES);
    well_set   = !exp_even_i && exp_odd_i && (odd_sel_i == N_ODD);
    if (!$isunknown({data_i, odd_sel_i, exp_even_i, exp_odd_i, flt_kind_i, flt_idx_i})) begin
      if (well_set && !fault_live) begin
        a_r1_clean_quiet: assert (!alarm_o)
          else $error("R1/R8: alarm raised on a fault-free cascade");
      end
      if (well_set && fault_live) begin
        a_r6_fault_flags: assert (alarm_o)
          else $error("R6/R7: injected fault at stage %0d not flagged", flt_idx_i);
      end
    end
  end

endmodule

// File: tb/dl_stage_checker_bench.sv
module dl_stage_checker_bench;

  localparam int N  = 6;
  localparam int W  = 4;
  localparam int IW = $clog2(N) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  data_i = '0;
  logic          odd_sel_i = 1'b0, exp_even_i = 1'b0, exp_odd_i = 1'b1;
  logic [1:0]    flt_kind_i = 2'd0;
  logic [IW-1:0] flt_idx_i = '0;
  logic [W-1:0]  data_o;
  logic          alarm_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dl_stage_checker #(.N_STAGES(N), .DATA_W(W)) u_dl_stage_checker (
    .data_i(data_i), .odd_sel_i(odd_sel_i), .exp_even_i(exp_even_i),
    .exp_odd_i(exp_odd_i), .flt_kind_i(flt_kind_i), .flt_idx_i(flt_idx_i),
    .data_o(data_o), .alarm_o(alarm_o));

  // Lane rules from R3/R4, with fault kinds from R6-R8.
  function automatic logic [W-1:0] model(input logic [W-1:0] d, input int kind, input int idx);
    logic [W-1:0] v;
    v = d;
    for (int k = 0; k < N; k++) begin
      int reps;
      reps = 1;
      if (idx == k && kind == 1) reps = 0;
      if (idx == k && kind == 2) reps = 2;
      for (int r = 0; r < reps; r++) begin
        if (k % 2 == 0) v[(k+2)%W] = v[(k+2)%W] ^ (v[k%W] & v[(k+1)%W]);
        else            v[(k+1)%W] = v[(k+1)%W] ^ v[k%W];
      end
    end
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] d, input logic sel, input logic ee, input logic eo,
                       input logic [1:0] kind, input logic [IW-1:0] idx);
    @(negedge clk);
    data_i = d; odd_sel_i = sel; exp_even_i = ee; exp_odd_i = eo;
    flt_kind_i = kind; flt_idx_i = idx;
    #2;
  endtask

  task automatic t_idle;
    apply('0, 1'b0, 1'b0, 1'b1, 2'd0, '0);
    chk("R1 idle alarm", 32'(alarm_o), 32'd0);
    chk("R9 idle data", 32'(data_o), 32'(model('0, 0, 0)));
  endtask

  task automatic t_clean;
    for (int d = 0; d < 16; d++) begin
      apply(W'(d), 1'b0, 1'b0, 1'b1, 2'd0, '0);
      chk("R1 clean alarm", 32'(alarm_o), 32'd0);
      chk("R3 R4 clean data", 32'(data_o), 32'(model(W'(d), 0, 0)));
    end
  endtask

  task automatic t_faults(input int kind);
    logic [W-1:0] pats [3] = '{4'hF, 4'h5, 4'hB};
    for (int k = 0; k < N; k++) begin
      for (int p = 0; p < 3; p++) begin
        apply(pats[p], 1'b0, 1'b0, 1'b1, 2'(kind), IW'(k));
        chk(kind == 1 ? "R6 skip alarm" : "R7 repeat alarm", 32'(alarm_o), 32'd1);
        chk(kind == 1 ? "R6 skip data" : "R7 repeat data", 32'(data_o), 32'(model(pats[p], kind, k)));
        apply(pats[p], 1'b1, 1'b0, 1'b1, 2'(kind), IW'(k));
        chk("R2 odd count clears alarm", 32'(alarm_o), 32'd0);
      end
    end
  endtask

  task automatic t_select;
    apply(4'h7, 1'b1, 1'b0, 1'b1, 2'd0, '0);
    chk("R5 wrong parity select", 32'(alarm_o), 32'd1);
    apply(4'h7, 1'b0, 1'b1, 1'b0, 2'd0, '0);
    chk("R5 even expectation 1", 32'(alarm_o), 32'd1);
    apply(4'h7, 1'b1, 1'b1, 1'b0, 2'd0, '0);
    chk("R5 odd expectation 0", 32'(alarm_o), 32'd0);
    apply(4'h7, 1'b0, 1'b0, 1'b0, 2'd0, '0);
    chk("R5 both expect 0", 32'(alarm_o), 32'd0);
  endtask

  task automatic t_inert;
    apply(4'hD, 1'b0, 1'b0, 1'b1, 2'd3, IW'(2));
    chk("R8 reserved kind alarm", 32'(alarm_o), 32'd0);
    chk("R8 reserved kind data", 32'(data_o), 32'(model(4'hD, 0, 0)));
    for (int i = N; i < (1 << IW); i += 3) begin
      apply(4'hE, 1'b0, 1'b0, 1'b1, 2'd1, IW'(i));
      chk("R8 out-of-range skip alarm", 32'(alarm_o), 32'd0);
      apply(4'hE, 1'b0, 1'b0, 1'b1, 2'd2, IW'(i));
      chk("R8 out-of-range repeat alarm", 32'(alarm_o), 32'd0);
      chk("R8 out-of-range data", 32'(data_o), 32'(model(4'hE, 0, 0)));
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_idle();
    t_clean();
    t_faults(1);
    t_faults(2);
    t_select();
    t_inert();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule